// File: doc/BRIEF.md
# Serial read checksum accumulator

This block runs next to the data-out shifter of a synchronous serial register port. During every register read it counts the one bits as they leave on the serial data line. When the read ends, the host can fetch that count and compare it with the ones in the word it received. A mismatch means at least one bit was corrupted on the wire. All logic runs on the rising edge of the serial clock.

A read begins with a one-cycle start strobe. That edge clears the count. A strobe qualifies each outgoing bit, and each qualified one adds to the count. The count is also presented as a register word for the port's read multiplexer, at a fixed address of its own.

When the host reads that address, the shifter captures the old count at the start edge, just before the clear takes effect. The new count is then built from the bits of that old value as they are shifted out. So reading the checksum register yields a checksum of the checksum.

Top module: `rdsum_accum`

## Requirements
- R1: A synchronous active-high reset drives the count to 0 at the next rising clock edge, including in the middle of a read.
- R2: An edge with the start strobe high and the bit strobe low leaves the count at 0, whatever the previous value.
- R3: An edge with the bit strobe high and the start strobe low adds the data bit to the count (a 1 adds one, a 0 leaves it unchanged). An edge with both strobes high clears the count and counts that first bit, giving 0 or 1.
- R4: On an edge with the bit strobe low and the start strobe low, the count holds whatever the data line does. This covers command phases and write transfers, so the last read's result is kept.
- R5: After a read of 8, 16 or 24 bits sent most significant bit first, the count equals the number of ones in the word that was sent.
- R6: The count is 6 bits wide and wraps modulo 64: a one counted while the count is 63 gives 0.
- R7: The register word output is 8 bits wide. When the address input equals 0x3E it carries the count in bits 5:0, with bits 7:6 at 0. For any other address it is 0.
- R8: When address 0x3E is read, the register word in the start cycle shows the pre-clear count. After those 8 bits are shifted out, the count equals the number of ones in that old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | One-cycle strobe marking the first edge of a read |
| rd_addr | input | 6 | Address of the register being read |
| sdo_bit | input | 1 | Bit currently driven onto the serial data output |
| bit_valid | input | 1 | High when sdo_bit is a read data bit to be counted |
| csum | output | 6 | Current checksum count |
| reg_word | output | 8 | Checksum presented as a readable register word |

## Verification
On every cycle, the embedded properties check the step rules. Reset and start strobes clear the count, a first bit seeds it, zeros and idle edges leave it unchanged, and a one added at 63 wraps to 0. They also check that the register word is zero off its address and zero in its padding bits. Only the bench's scenarios can show the properties of whole transfers. These are that a complete read of 1 to 3 bytes ends with the word's ones count, that random gaps in the bit strobe change nothing, and that a self-read counts the snapshot of the previous result rather than the cleared value.

// File: rtl/rdsum_pkg.sv
package rdsum_pkg;

    // Default geometry of the checksum register
    localparam int SUM_W_DEF   = 6;
    localparam int WORD_W_DEF  = 8;
    localparam int ADDR_W_DEF  = 6;
    localparam int MAX_BITS    = 24;

    // One serial-clock event seen by the accumulator
    typedef struct packed {
        logic start;
        logic valid;
        logic data;
    } ser_evt_t;

    // Action the counter takes on an edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SEED  = 2'd2,
        OP_ACC   = 2'd3
    } acc_op_e;

    // Start has priority: it clears, and a bit arriving in the same
    // cycle becomes the first counted bit.
    function automatic acc_op_e decode_op(input ser_evt_t evt);
        acc_op_e op;
        if (evt.start)
            op = evt.valid ? OP_SEED : OP_CLEAR;
        else if (evt.valid)
            op = OP_ACC;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/rdsum_decode.sv
module rdsum_decode
    import rdsum_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t evt_i,
    output acc_op_e  op_o,
    output logic     data_o
);

    always_comb begin
        op_o   = decode_op(evt_i);
        data_o = evt_i.data;
    end

    // R2/R3: a start strobe must never be decoded as hold or plain accumulate
    a_r2_start_decodes: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |-> (op_o == OP_CLEAR || op_o == OP_SEED));

endmodule

// File: rtl/rdsum_counter.sv
module rdsum_counter
    import rdsum_pkg::*;
#(
    parameter int SUM_W = SUM_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_op_e          op_i,
    input  logic             data_i,
    output logic [SUM_W-1:0] sum_o
);

    localparam logic [SUM_W-1:0] SUM_ZERO = '0;
    localparam logic [SUM_W-1:0] SUM_TOP  = {SUM_W{1'b1}};

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_d;
    logic [SUM_W-1:0] bit_ext;

    assign bit_ext = {{(SUM_W-1){1'b0}}, data_i};

    always_comb begin
        unique case (op_i)
            OP_CLEAR: sum_d = SUM_ZERO;
            OP_SEED:  sum_d = bit_ext;
            OP_ACC:   sum_d = sum_q + bit_ext;   // modular, no saturation
            default:  sum_d = sum_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= SUM_ZERO;
        else
            sum_q <= sum_d;
    end

    assign sum_o = sum_q;

    // R1: reset clears
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sum_o == SUM_ZERO));

    // R2: start without a bit leaves zero
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLEAR) |=> (sum_o == SUM_ZERO));

    // R3: the first bit lands on a cleared count
    a_r3_seed_first_bit: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SEED) |=> (sum_o <= 1));

    // R3: a counted zero changes nothing
    a_r3_zero_no_change: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ACC && !data_i) |=> $stable(sum_o));

    // R3: a counted one always moves the count
    a_r3_one_moves: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ACC && data_i) |=> (sum_o != $past(sum_o)));

    // R4: idle edges hold
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_HOLD) |=> $stable(sum_o));

    // R6: wrap from the top value to zero
    a_r6_wraps: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ACC && data_i && sum_o == SUM_TOP) |=> (sum_o == SUM_ZERO));

endmodule

// File: rtl/rdsum_regview.sv
module rdsum_regview
    import rdsum_pkg::*;
#(
    parameter int                SUM_W     = SUM_W_DEF,
    parameter int                WORD_W    = WORD_W_DEF,
    parameter int                ADDR_W    = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] CSUM_ADDR = 6'h3E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SUM_W-1:0]  sum_i,
    output logic [WORD_W-1:0] word_o
);

    logic              hit;
    logic [WORD_W-1:0] shaped;

    assign hit = (addr_i == CSUM_ADDR);

    generate
        if (WORD_W > SUM_W) begin : g_pad
            localparam int PAD_W = WORD_W - SUM_W;
            assign shaped = {{PAD_W{1'b0}}, sum_i};

            // R7: padding bits read as zero
            a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
                word_o[WORD_W-1:SUM_W] == '0);
        end else begin : g_trunc
            assign shaped = sum_i[WORD_W-1:0];
        end
    endgenerate

    assign word_o = hit ? shaped : '0;

    // R7: other addresses see nothing from this register
    a_r7_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (addr_i != CSUM_ADDR) |-> (word_o == '0));

endmodule

// File: rtl/rdsum_accum.sv
module rdsum_accum
    import rdsum_pkg::*;
#(
    parameter int                SUM_W     = SUM_W_DEF,
    parameter int                WORD_W    = WORD_W_DEF,
    parameter int                ADDR_W    = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] CSUM_ADDR = 6'h3E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sdo_bit,
    input  logic              bit_valid,
    output logic [SUM_W-1:0]  csum,
    output logic [WORD_W-1:0] reg_word
);

    ser_evt_t evt;
    acc_op_e  op;
    logic     op_data;

    assign evt = '{start: rd_start, valid: bit_valid, data: sdo_bit};

    rdsum_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .op_o   (op),
        .data_o (op_data)
    );

    rdsum_counter #(
        .SUM_W (SUM_W)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .data_i (op_data),
        .sum_o  (csum)
    );

    rdsum_regview #(
        .SUM_W     (SUM_W),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .CSUM_ADDR (CSUM_ADDR)
    ) u_regview (
        .clk    (clk),
        .rst    (rst),
        .addr_i (rd_addr),
        .sum_i  (csum),
        .word_o (reg_word)
    );

    // R8: in a self-read start cycle the word carries the pre-clear count
    a_r8_snapshot_before_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_start && rd_addr == CSUM_ADDR) |-> (reg_word[SUM_W-1:0] == csum));

endmodule

// File: tb/rdsum_accum_tb_top.sv
module rdsum_accum_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [5:0] SELF_ADDR  = 6'h3E;

    logic       clk       = 1'b0;
    logic       rst       = 1'b1;
    logic       rd_start  = 1'b0;
    logic [5:0] rd_addr   = 6'h00;
    logic       sdo_bit   = 1'b0;
    logic       bit_valid = 1'b0;
    logic [5:0] csum;
    logic [7:0] reg_word;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdsum_accum dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .sdo_bit   (sdo_bit),
        .bit_valid (bit_valid),
        .csum      (csum),
        .reg_word  (reg_word)
    );

    function automatic int ones(input logic [31:0] w, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += w[i];
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One edge; inputs change 1 time unit after the edge, outputs sampled there too
    task automatic step(input bit rs, input bit bv, input bit b);
        rd_start  = rs;
        bit_valid = bv;
        sdo_bit   = b;
        @(posedge clk);
        #1;
        if (rs)      model = bv ? int'(b) : 0;
        else if (bv) model = (model + int'(b)) % 64;
        rd_start  = 1'b0;
        bit_valid = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] w, input int nbits, input bit gaps);
        for (int i = nbits - 1; i >= 0; i--) begin
            step(i == nbits - 1, 1'b1, w[i]);
            chk("R3 running count", int'(csum), model);
            if (gaps && ($urandom % 3 == 0)) begin
                step(1'b0, 1'b0, 1'($urandom));
                chk("R4 gap holds", int'(csum), model);
            end
        end
        chk("R5 read ones count", int'(csum), ones({8'h00, w}, nbits) % 64);
    endtask

    task automatic self_read(input bit gaps);
        logic [7:0] snap;
        rd_addr = SELF_ADDR;
        #1;
        snap = reg_word;
        chk("R8 snapshot equals previous count", int'(snap), model);
        do_read({16'h0000, snap}, 8, gaps);
        chk("R8 self checksum", int'(csum), ones({24'h0, snap}, 8));
        chk("R7 word at own address", int'(reg_word), model);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, -1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rd_addr = SELF_ADDR;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset count", int'(csum), 0);
        chk("R1 reset word", int'(reg_word), 0);
        rst = 1'b0;
        model = 0;

        // R5 full 24-bit word
        do_read(24'hFFFFFF, 24, 1'b0);
        chk("R7 word shows 24", int'(reg_word), 24);
        // R2 start without bit
        step(1'b1, 1'b0, 1'b1);
        chk("R2 start clears", int'(csum), 0);
        // R3 start with first bit
        do_read(24'hB4, 8, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R3 seed with one", int'(csum), 1);
        step(1'b0, 1'b1, 1'b0);
        chk("R3 zero adds nothing", int'(csum), 1);
        step(1'b0, 1'b1, 1'b1);
        chk("R3 one adds one", int'(csum), 2);
        step(1'b1, 1'b1, 1'b0);
        chk("R3 seed with zero", int'(csum), 0);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        // R4 idle edges with toggling data (write/command phase)
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b0, 1'(i));
            chk("R4 idle hold", int'(csum), 2);
        end
        // R6 wrap: 70 ones
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 70; i++) begin
            step(1'b0, 1'b1, 1'b1);
            if (i == 62) chk("R6 reaches 63", int'(csum), 63);
            if (i == 63) chk("R6 wraps to 0", int'(csum), 0);
        end
        chk("R6 wrapped count", int'(csum), 6);
        // R7 other address
        rd_addr = 6'h15;
        #1;
        chk("R7 other address zero", int'(reg_word), 0);
        rd_addr = SELF_ADDR;
        #1;
        chk("R7 own address", int'(reg_word), 6);
        // R8 self reads
        do_read(24'hA5, 8, 1'b0);
        self_read(1'b0);
        chk("R8 count of 4", int'(csum), 1);
        self_read(1'b1);
        chk("R8 count of 1", int'(csum), 1);
        do_read(24'h3F, 8, 1'b0);
        self_read(1'b0);
        chk("R8 count of 6", int'(csum), 2);
        // R1 reset mid-read
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model = 0;
        chk("R1 mid-read reset", int'(csum), 0);

        // Random reads
        for (int n = 0; n < 300; n++) begin
            int nb;
            logic [23:0] w;
            nb = 8 * (1 + int'($urandom % 3));
            w  = 24'($urandom);
            if ($urandom % 4 == 0) begin
                self_read(1'($urandom));
            end else begin
                rd_addr = 6'($urandom);
                do_read(w, nb, 1'($urandom));
                #1;
                chk("R7 random address view", int'(reg_word),
                    (rd_addr == SELF_ADDR) ? model : 0);
            end
            if ($urandom % 5 == 0) begin
                int keep;
                keep = model;
                for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'($urandom));
                chk("R4 random idle hold", int'(csum), keep);
            end
        end
        finish_run();
    end

endmodule